// File: doc/BRIEF.md
# Armed Sleep Wake Timer

This block wakes a processor from its low-power sleep mode or its display-only mode after a programmed number of seconds. Software writes an 8-bit interval value into a retained register and then arms the timer with a single pulse. From then on, every entry into either low-power mode restarts the count from the retained value. The block drops the wake signal and holds the processor in reset while the timer runs. When the count expires, wake rises again, a timer wake flag records the cause, and the processor reset is released on the following cycle.

The block runs on the slow 32768 Hz clock. A divider of `DIV_BITS` bits turns that clock into one-second ticks. The divider clears whenever a run starts, so the first second of every interval is a full second. An arm pulse needs a few cycles to take effect, so software must arm the timer at least three slow cycles before it asks for a low-power mode. Once armed, the timer stays armed across wake-ups. A block reset disarms it. The interval register has no reset, so it keeps its value through a block reset. A separate wake input lets other wake sources end a low-power period.

Top module: `sleep_wake_timer`

## Requirements
- R1: After reset, `wake` is 1, `cpu_hold` is 0 and `tmr_flag` is 0, and the timer is unarmed.
- R2: The request edge is the clock edge that samples `sleep_req` or `lcd_req` while the timer is armed. Call the stored interval D. `wake` is still 0 after edge (D+1)*2^DIV_BITS - 1, counted from the request edge, and is 1 after edge (D+1)*2^DIV_BITS.
- R3: After any edge that samples `sleep_req` or `lcd_req`, `wake` is 0, `tmr_flag` is 0 and `cpu_hold` is 1. The two requests behave identically.
- R4: `tmr_flag` becomes 1 in the same cycle that `wake` rises because the timer expired. The flag stays 0 when `wake` rises for any other reason.
- R5: `cpu_hold` returns to 0 one cycle after `wake` rises.
- R6: A request made while the timer is unarmed leaves `wake` at 0 indefinitely. Only `ext_wake` can end that sleep.
- R7: An edge that samples `arm_set` is followed by a lead time before the timer is armed. A request sampled one or two edges after that edge does not start the timer. A request sampled three or more edges after it does start the timer.
- R8: The timer stays armed after it wakes the processor. Each later request restarts a full interval taken from the value the interval register holds at that request.
- R9: The interval register keeps its value through `rst`, but `rst` disarms the timer.
- R10: If `ext_wake` is sampled while `wake` is 0 and no request is sampled in the same cycle, `wake` becomes 1 on the next cycle with `tmr_flag` at 0. The running interval is abandoned and sets no flag later.
- R11: A request sampled on the same edge as the expiry wins. `wake` stays 0, `tmr_flag` stays 0, and a new full interval starts from that edge.
- R12: A request sampled while the timer is running restarts a full interval from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock, 32768 Hz nominal |
| rst | input | 1 | Synchronous active-high reset |
| dur_we | input | 1 | Write strobe for the retained interval register |
| dur_wdata | input | 8 | Interval value D; the wake period is D+1 seconds |
| arm_set | input | 1 | Arm pulse; also presets the counter from the interval register |
| sleep_req | input | 1 | Software request to enter sleep mode |
| lcd_req | input | 1 | Software request to enter display-only mode |
| ext_wake | input | 1 | Wake event from another source |
| wake | output | 1 | High while the processor is awake |
| cpu_hold | output | 1 | High while the processor is held in reset |
| tmr_flag | output | 1 | Set when the timer caused the last wake-up |

## Verification
A low-power request and the timer expiry can fall on the same clock edge. The bench provokes this by issuing a second request exactly (D+1)*2^DIV_BITS cycles after the first one. The collision is judged correct if `wake` and `tmr_flag` both stay low on that edge and `wake` then rises one full interval later. A second overlap is also tested: an `ext_wake` during a running interval must raise `wake` without the flag, and the flag must stay low past the point where the abandoned interval would have expired.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int DUR_W = 8;
  typedef logic [DUR_W-1:0] dur_t;
endpackage

// File: rtl/wkt_arm_sync.sv
module wkt_arm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_set,
  output logic arm_load,
  output logic armed
);
  logic [STAGES-1:0] pipe_q;
  logic              armed_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= arm_set;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-2:0], arm_set};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else if (pipe_q[STAGES-1]) armed_q <= 1'b1;
  end

  assign arm_load = pipe_q[STAGES-1];
  assign armed    = armed_q;
endmodule

// File: rtl/wkt_sec_div.sv
module wkt_sec_div #(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam logic [DIV_BITS-1:0] DIV_LAST = '1;
  logic [DIV_BITS-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  assign tick = run && (div_q == DIV_LAST);
endmodule

// File: rtl/wkt_sec_count.sv
module wkt_sec_count
  import wkt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  dur_t load_val,
  input  logic tick,
  output logic expire
);
  dur_t cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = tick && (cnt_q == '0);
endmodule

// File: rtl/sleep_wake_timer.sv
module sleep_wake_timer
  import wkt_pkg::*;
#(
  parameter int DIV_BITS   = 15,
  parameter int ARM_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dur_we,
  input  logic [7:0] dur_wdata,
  input  logic       arm_set,
  input  logic       sleep_req,
  input  logic       lcd_req,
  input  logic       ext_wake,
  output logic       wake,
  output logic       cpu_hold,
  output logic       tmr_flag
);
  dur_t dur_q = '0;
  logic req, start, armed, arm_load, tick, expire, cnt_load;
  logic running_q, wake_q, hold_q, flag_q;

  assign req   = sleep_req | lcd_req;
  assign start = req & armed;

  // retained interval register: deliberately outside the block reset
  always_ff @(posedge clk) begin
    if (dur_we) dur_q <= dur_wdata;
  end

  wkt_arm_sync #(.STAGES(ARM_STAGES)) u_arm (
    .clk(clk), .rst(rst), .arm_set(arm_set),
    .arm_load(arm_load), .armed(armed)
  );

  wkt_sec_div #(.DIV_BITS(DIV_BITS)) u_div (
    .clk(clk), .rst(rst), .run(running_q), .restart(start), .tick(tick)
  );

  assign cnt_load = start | (arm_load & ~running_q);

  wkt_sec_count u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(dur_q),
    .tick(tick), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      wake_q    <= 1'b1;
      flag_q    <= 1'b0;
      hold_q    <= 1'b0;
    end else if (req) begin
      running_q <= armed;
      wake_q    <= 1'b0;
      flag_q    <= 1'b0;
      hold_q    <= 1'b1;
    end else begin
      if (expire || (ext_wake && !wake_q)) running_q <= 1'b0;
      if (expire || ext_wake)              wake_q    <= 1'b1;
      if (expire)                          flag_q    <= 1'b1;
      hold_q <= ~wake_q;
    end
  end

  assign wake     = wake_q;
  assign cpu_hold = hold_q;
  assign tmr_flag = flag_q;
endmodule

// File: rtl/sleep_wake_timer_chk.sv
module sleep_wake_timer_chk (
  input logic clk,
  input logic rst,
  input logic sleep_req,
  input logic lcd_req,
  input logic ext_wake,
  input logic wake,
  input logic cpu_hold,
  input logic tmr_flag
);
  AST_REQ_SLEEPS: assert property (@(posedge clk) disable iff (rst)
    (sleep_req || lcd_req) |=> (!wake && !tmr_flag && cpu_hold)); // R3
  AST_ASLEEP_HELD: assert property (@(posedge clk) disable iff (rst)
    !wake |-> cpu_hold); // R3
  AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(tmr_flag) |-> $rose(wake)); // R4
  AST_FLAG_AWAKE: assert property (@(posedge clk) disable iff (rst)
    tmr_flag |-> wake); // R4
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($rose(wake) && !sleep_req && !lcd_req) |=> !cpu_hold); // R5
  AST_EXT_WAKES: assert property (@(posedge clk) disable iff (rst)
    (ext_wake && !wake && !sleep_req && !lcd_req) |=> (wake && !tmr_flag)); // R10
endmodule

bind sleep_wake_timer sleep_wake_timer_chk u_chk (
  .clk(clk), .rst(rst), .sleep_req(sleep_req), .lcd_req(lcd_req),
  .ext_wake(ext_wake), .wake(wake), .cpu_hold(cpu_hold), .tmr_flag(tmr_flag)
);

// File: tb/sleep_wake_timer_bench.sv
module sleep_wake_timer_bench;
  localparam int DIV_BITS = 3;
  localparam int SEC = 1 << DIV_BITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dur_we = 1'b0;
  logic [7:0] dur_wdata = '0;
  logic arm_set = 1'b0, sleep_req = 1'b0, lcd_req = 1'b0, ext_wake = 1'b0;
  logic wake, cpu_hold, tmr_flag;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_wake_timer #(.DIV_BITS(DIV_BITS), .ARM_STAGES(2)) u_sleep_wake_timer (
    .clk(clk), .rst(rst), .dur_we(dur_we), .dur_wdata(dur_wdata),
    .arm_set(arm_set), .sleep_req(sleep_req), .lcd_req(lcd_req),
    .ext_wake(ext_wake), .wake(wake), .cpu_hold(cpu_hold), .tmr_flag(tmr_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      finish_run();
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_dur(input logic [7:0] v);
    dur_we = 1'b1; dur_wdata = v;
    @(negedge clk);
    dur_we = 1'b0;
  endtask

  task automatic pulse_arm();
    arm_set = 1'b1;
    @(negedge clk);
    arm_set = 1'b0;
  endtask

  task automatic pulse_req(input bit use_lcd);
    if (use_lcd) lcd_req = 1'b1; else sleep_req = 1'b1;
    @(negedge clk);
    lcd_req = 1'b0; sleep_req = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_wake = 1'b1;
    @(negedge clk);
    ext_wake = 1'b0;
  endtask

  // called right after the request edge; checks the wake-up P edges later
  task automatic expect_wake_after(input int p, input string tag);
    repeat (p - 1) @(negedge clk);
    check({tag, "/R2 wake before expiry"}, wake, 0);
    @(negedge clk);
    check({tag, "/R2 wake at expiry"}, wake, 1);
    check({tag, "/R4 flag at expiry"}, tmr_flag, 1);
    check({tag, "/R5 hold still set"}, cpu_hold, 1);
    @(negedge clk);
    check({tag, "/R5 hold released"}, cpu_hold, 0);
  endtask

  task automatic t_reset();
    check("R1 wake", wake, 1);
    check("R1 hold", cpu_hold, 0);
    check("R1 flag", tmr_flag, 0);
  endtask

  task automatic t_unarmed();
    set_dur(8'd0);
    pulse_req(1'b0);
    check("R3 wake low", wake, 0);
    check("R3 hold", cpu_hold, 1);
    repeat (5 * SEC) @(negedge clk);
    check("R6 unarmed stays asleep", wake, 0);
    check("R6 no flag", tmr_flag, 0);
    pulse_ext();
    check("R10 ext wake", wake, 1);
    check("R10 no flag", tmr_flag, 0);
    @(negedge clk);
    check("R10 hold released", cpu_hold, 0);
  endtask

  task automatic t_period(input logic [7:0] d, input bit use_lcd);
    set_dur(d);
    pulse_arm();
    repeat (2) @(negedge clk);
    pulse_req(use_lcd);
    check("R3 request drops wake", wake, 0);
    check("R3 request clears flag", tmr_flag, 0);
    expect_wake_after((int'(d) + 1) * SEC, use_lcd ? "R2 lcd" : "R2 sleep");
  endtask

  task automatic t_persist();
    pulse_req(1'b0);
    expect_wake_after(3 * SEC, "R8 rerun");
    set_dur(8'd0);
    pulse_req(1'b1);
    expect_wake_after(SEC, "R8 new value");
  endtask

  task automatic t_arm_lead();
    do_reset();
    set_dur(8'd0);
    pulse_arm();
    @(negedge clk);
    pulse_req(1'b0);
    repeat (3 * SEC) @(negedge clk);
    check("R7 early request ignored", wake, 0);
    pulse_ext();
    @(negedge clk);
    pulse_req(1'b0);
    expect_wake_after(SEC, "R7 armed later");
  endtask

  task automatic t_retain();
    set_dur(8'd1);
    do_reset();
    pulse_req(1'b0);
    repeat (4 * SEC) @(negedge clk);
    check("R9 reset disarms", wake, 0);
    pulse_ext();
    @(negedge clk);
    pulse_arm();
    repeat (2) @(negedge clk);
    pulse_req(1'b0);
    expect_wake_after(2 * SEC, "R9 value retained");
  endtask

  task automatic t_collide();
    pulse_req(1'b0);
    repeat (2 * SEC - 1) @(negedge clk);
    check("R11 before collision", wake, 0);
    pulse_req(1'b1);
    check("R11 wake stays low", wake, 0);
    check("R11 flag stays low", tmr_flag, 0);
    expect_wake_after(2 * SEC, "R11 new interval");
  endtask

  task automatic t_restart();
    pulse_req(1'b0);
    repeat (5) @(negedge clk);
    pulse_req(1'b0);
    expect_wake_after(2 * SEC, "R12 restart");
  endtask

  task automatic t_ext_running();
    pulse_req(1'b0);
    repeat (4) @(negedge clk);
    pulse_ext();
    check("R10 ext during run", wake, 1);
    check("R10 ext no flag", tmr_flag, 0);
    repeat (3 * SEC) @(negedge clk);
    check("R10 abandoned run no flag", tmr_flag, 0);
    check("R10 stays awake", wake, 1);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_period(8'd2, 1'b0);
    t_persist();
    t_period(8'd0, 1'b1);
    t_period(8'd255, 1'b0);
    t_arm_lead();
    t_retain();
    t_collide();
    t_restart();
    t_ext_running();
    finish_run();
  end
endmodule